// File: doc/BRIEF.md
# Bit-Serial Time-Shift Multiplier

This block multiplies an operand A, which arrives one bit per clock on a single wire, by a narrow parallel operand B. The product leaves the block LSB first on a single wire. A one-cycle `start` pulse latches B. The block then asks for the A bits, lowest first, over `A_W` consecutive cycles. It returns the `A_W + B_W` product bits over consecutive cycles, marked by `p_valid`.

Inside, each B bit gates the A stream into its own partial-product stream. The stream for B bit j is delayed by j cycles, and that delay gives it the weight 2^j. Each cycle the block counts the partial-product bits that are high, adds the carry bits that arrive that cycle, and splits the count into binary. Bit 0 of the count is the output bit for the cycle. Every bit k above zero goes back into a delay line of length k and adds 1 to the count k cycles later. The count width is derived from `B_W`, so the count always fits.

Top module: `tsm_serial_mult`

## Requirements
- R1: After a synchronous reset, `busy`, `a_take`, `p_valid`, `p_last` and `p_bit` are all 0.
- R2: A `start` pulse seen while idle latches `b_in`. `a_take` is then high for exactly `A_W` cycles, starting the cycle after the `start` edge. `a_bit` is sampled in those cycles only, A bit 0 first. The value of `a_bit` in any other cycle has no effect on the product.
- R3: For an accepted `start` in cycle s, `p_valid` is high from cycle s+2 to cycle s+1+`A_W`+`B_W` inclusive and low at all other times.
- R4: The bits on `p_bit` in the `p_valid` cycles, in order, are product bits 0 to `A_W+B_W-1` of A*B. `p_bit` is 0 whenever `p_valid` is 0.
- R5: Changes on `b_in` after the `start` cycle do not affect the product being produced.
- R6: A `start` pulse that arrives while `busy` is high is ignored. The run in progress completes unchanged.
- R7: No carry state from one run remains when the next begins. A new run accepted in the first idle cycle gives a correct product.
- R8: The per-cycle count of partial products plus arriving carries never exceeds the range of the count register.
- R9: The product is correct at the boundaries: A or B zero, A and B all ones, and A or B with a single bit set. This includes B patterns 0011, 0101 and 1001.
- R10: `p_last` is high only in the final `p_valid` cycle of a run, once per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run and latch `b_in` (ignored while busy) |
| b_in | input | B_W | Parallel operand B |
| a_bit | input | 1 | Serial operand A, one bit per cycle while `a_take` is high |
| a_take | output | 1 | High in the cycles in which `a_bit` is consumed |
| busy | output | 1 | A run is in progress |
| p_bit | output | 1 | Serial product bit, LSB first |
| p_valid | output | 1 | `p_bit` carries a product bit |
| p_last | output | 1 | Final product bit of the run |

## Verification
The bench uses operand pairs chosen to stress the carry loop:

- **All-ones operands.** These hold the count at its peak for many cycles. A count register that is too narrow, or a carry re-injected with the wrong delay, corrupts the upper product bits.
- **Back-to-back runs.** A run started in the first idle cycle would show any carry left over from the previous run as a wrong low-order bit.
- **Stray inputs.** Junk on `a_bit` outside the take window and a changing `b_in` during a run catch a design that samples too long or reads B live.
- **Start while busy.** A `start` pulse during a run would restart or corrupt a design that does not lock out new runs, and the product stream would show it.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    // Width of the per-cycle count. The count holds up to bw partial products
    // plus one arriving carry from each of the (c-1) delay lines, so 2^c >= bw + c.
    function automatic int count_width(input int bw);
        int c;
        c = 1;
        for (int i = 1; i < 32; i++) begin
            if ((1 << c) < bw + c) c = c + 1;
        end
        return c;
    endfunction

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } run_state_e;

    typedef struct packed {
        logic data;
        logic valid;
        logic last;
    } ser_out_s;

endpackage

// File: rtl/tsm_ctrl.sv
module tsm_ctrl #(
    parameter int A_W = 32,
    parameter int B_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic run,
    output logic take,
    output logic load,
    output logic final_cyc
);
    import tsm_pkg::*;

    localparam int N  = A_W + B_W;
    localparam int PW = $clog2(N + 1);

    run_state_e     state;
    logic [PW-1:0]  phase;

    assign run       = (state == PH_RUN);
    assign load      = start && (state == PH_IDLE);
    assign take      = run && (phase < PW'(A_W));
    assign final_cyc = run && (phase == PW'(N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PH_IDLE;
            phase <= '0;
        end else if (load) begin
            state <= PH_RUN;
            phase <= '0;
        end else if (run) begin
            if (final_cyc) begin
                state <= PH_IDLE;
                phase <= '0;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (phase < PW'(N)));  // R3

    AST_RUN_ENDS: assert property (@(posedge clk) disable iff (rst)
        final_cyc |=> !run);  // R3

endmodule

// File: rtl/tsm_pp_stage.sv
module tsm_pp_stage #(
    parameter int B_W = 4,
    parameter int CW  = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clear,
    input  logic           a_in,
    input  logic [B_W-1:0] b_vec,
    output logic [CW-1:0]  pp_cnt
);
    localparam int DW = (B_W > 1) ? B_W - 1 : 1;

    logic [DW-1:0]  a_dl;
    logic [B_W-1:0] taps;

    assign taps[0] = a_in;

    generate
        if (B_W > 1) begin : g_dl
            always_ff @(posedge clk) begin
                if (rst || clear) a_dl <= '0;
                else if (DW == 1) a_dl <= DW'(a_in);
                else              a_dl <= {a_dl[DW-2:0], a_in};
            end
            for (genvar j = 1; j < B_W; j++) begin : g_tap
                assign taps[j] = a_dl[j-1];
            end
        end else begin : g_nodl
            always_ff @(posedge clk) a_dl <= '0;
        end
    endgenerate

    always_comb begin
        pp_cnt = '0;
        for (int j = 0; j < B_W; j++) begin
            pp_cnt = pp_cnt + CW'(taps[j] & b_vec[j]);
        end
    end

endmodule

// File: rtl/tsm_carry_loop.sv
module tsm_carry_loop #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [CW-1:0] pp_cnt,
    output logic          out_bit,
    output logic          loop_idle
);
    localparam int WW = CW + 1;

    logic [CW-1:0] arrive;
    logic [WW-1:0] wide_sum;
    logic [CW-1:0] level;

    assign arrive[0] = 1'b0;

    generate
        for (genvar k = 1; k < CW; k++) begin : g_cl
            logic [k-1:0] dl;
            always_ff @(posedge clk) begin
                if (rst || clear) dl <= '0;
                else if (k == 1)  dl <= k'(level[k]);
                else              dl <= {dl[(k>1 ? k-2 : 0):0], level[k]};
            end
            assign arrive[k] = dl[k-1];
        end
    endgenerate

    always_comb begin
        wide_sum = WW'(pp_cnt);
        for (int k = 1; k < CW; k++) begin
            wide_sum = wide_sum + WW'(arrive[k]);
        end
    end

    assign level     = wide_sum[CW-1:0];
    assign out_bit   = level[0];
    assign loop_idle = (arrive == '0) && (wide_sum == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wide_sum[CW] == 1'b0);  // R8

endmodule

// File: rtl/tsm_serial_mult.sv
module tsm_serial_mult #(
    parameter int A_W = 32,
    parameter int B_W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [B_W-1:0] b_in,
    input  logic           a_bit,
    output logic           a_take,
    output logic           busy,
    output logic           p_bit,
    output logic           p_valid,
    output logic           p_last
);
    import tsm_pkg::*;

    localparam int CW = count_width(B_W);

    logic           run, take, load, final_cyc;
    logic [B_W-1:0] b_reg;
    logic           a_in;
    logic [CW-1:0]  pp_cnt;
    logic           sum_bit, loop_idle;
    ser_out_s       out_q;

    tsm_ctrl #(.A_W(A_W), .B_W(B_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .run(run), .take(take), .load(load), .final_cyc(final_cyc)
    );

    always_ff @(posedge clk) begin
        if (rst)       b_reg <= '0;
        else if (load) b_reg <= b_in;
    end

    assign a_in = take & a_bit;

    tsm_pp_stage #(.B_W(B_W), .CW(CW)) u_pp (
        .clk(clk), .rst(rst), .clear(load), .a_in(a_in),
        .b_vec(b_reg), .pp_cnt(pp_cnt)
    );

    tsm_carry_loop #(.CW(CW)) u_loop (
        .clk(clk), .rst(rst), .clear(load), .pp_cnt(pp_cnt),
        .out_bit(sum_bit), .loop_idle(loop_idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.data  <= run & sum_bit;
            out_q.valid <= run;
            out_q.last  <= final_cyc;
        end
    end

    assign a_take  = take;
    assign busy    = run;
    assign p_bit   = out_q.data;
    assign p_valid = out_q.valid;
    assign p_last  = out_q.last;

    AST_TAKE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        a_take |-> busy);  // R2

    AST_LAST_VALID: assert property (@(posedge clk) disable iff (rst)
        p_last |-> p_valid);  // R10

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(b_reg));  // R6

    AST_DRAINED: assert property (@(posedge clk) disable iff (rst)
        p_last |-> loop_idle);  // R7

    AST_BIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !p_valid |-> !p_bit);  // R4

endmodule

// File: tb/tsm_serial_mult_bench.sv
module tsm_serial_mult_bench;
    localparam int A_W = 32;
    localparam int B_W = 4;
    localparam int N   = A_W + B_W;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [B_W-1:0] b_in = '0;
    logic           a_bit = 1'b0;
    logic           a_take, busy, p_bit, p_valid, p_last;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    tsm_serial_mult #(.A_W(A_W), .B_W(B_W)) u_tsm_serial_mult (
        .clk(clk), .rst(rst), .start(start), .b_in(b_in), .a_bit(a_bit),
        .a_take(a_take), .busy(busy), .p_bit(p_bit),
        .p_valid(p_valid), .p_last(p_last)
    );

    // behavioural reference model
    logic [A_W-1:0] next_a = '0;
    logic [A_W-1:0] ma = '0;
    logic [N-1:0]   m_prod = '0;
    int  m_phase = 0;
    bit  m_run = 0;
    bit  e_valid = 0, e_bit = 0, e_last = 0, e_take = 0;

    always @(posedge clk) begin
        logic [N-1:0] xa, xb;
        if (rst) begin
            m_run = 0; m_phase = 0;
            e_valid = 0; e_bit = 0; e_last = 0; e_take = 0;
        end else begin
            e_valid = m_run;
            e_bit   = m_run ? m_prod[m_phase] : 1'b0;
            e_last  = m_run && (m_phase == N - 1);
            if (m_run) begin
                m_phase++;
                if (m_phase == N) begin m_run = 0; m_phase = 0; end
            end else if (start) begin
                ma = next_a;
                xa = N'(next_a);
                xb = N'(b_in);
                m_prod = xa * xb;
                m_run = 1; m_phase = 0;
            end
            e_take = m_run && (m_phase < A_W);
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) t=%0t actual=%b expected=%b", req, tag, $time, act, exp);
        end
    endtask

    // per-cycle comparison and A stream driver, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk("R3 p_valid", p_valid, e_valid);
            chk("R4 p_bit",   p_bit,   e_bit);
            chk("R10 p_last", p_last,  e_last);
            chk("R2 a_take",  a_take,  e_take);
        end
        if (m_run && m_phase < A_W) a_bit = ma[m_phase];
        else                        a_bit = 1'($urandom);
    end

    task automatic wait_idle();
        while (m_run) @(negedge clk);
    endtask

    task automatic run_op(input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                          input bit jitter_b, input bit busy_start);
        wait_idle();
        next_a = a;
        b_in   = b;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        for (int i = 0; i < N + 1; i++) begin
            if (jitter_b) b_in = B_W'($urandom);
            if (busy_start && i == 5) start = 1'b1;
            if (busy_start && i == 6) start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        vectors++; if (busy !== 1'b0)    begin errors++; $display("FAIL R1 busy actual=%b expected=0", busy); end
        vectors++; if (a_take !== 1'b0)  begin errors++; $display("FAIL R1 a_take actual=%b expected=0", a_take); end
        vectors++; if (p_valid !== 1'b0) begin errors++; $display("FAIL R1 p_valid actual=%b expected=0", p_valid); end
        vectors++; if (p_last !== 1'b0)  begin errors++; $display("FAIL R1 p_last actual=%b expected=0", p_last); end
        vectors++; if (p_bit !== 1'b0)   begin errors++; $display("FAIL R1 p_bit actual=%b expected=0", p_bit); end
        rst = 1'b0;
        repeat (2) @(negedge clk);

        tag = "R9";
        run_op(32'h0000_00B5, 4'b0011, 0, 0);
        run_op(32'h0000_0000, 4'b1111, 0, 0);
        run_op(32'hDEAD_BEEF, 4'b0000, 0, 0);
        run_op(32'hFFFF_FFFF, 4'b1111, 0, 0);
        run_op(32'h8000_0000, 4'b1000, 0, 0);
        run_op(32'h0000_0001, 4'b0001, 0, 0);
        run_op(32'hC3A5_5A3C, 4'b0101, 0, 0);
        run_op(32'hF0F0_1234, 4'b1001, 0, 0);
        run_op(32'hFFFF_FFFF, 4'b0011, 0, 0);

        tag = "R7";
        for (int i = 0; i < 6; i++) begin
            run_op(32'hFFFF_FFFF - 32'(i), B_W'(15 - i), 0, 0);
        end

        tag = "R5";
        run_op(32'h1357_9BDF, 4'b1011, 1, 0);
        run_op(32'hFFFF_FFFF, 4'b1111, 1, 0);

        tag = "R6";
        run_op(32'h2468_ACE0, 4'b0111, 0, 1);
        run_op(32'hFFFF_0000, 4'b1101, 1, 1);

        tag = "R8";
        for (int i = 0; i < 8; i++) begin
            run_op($urandom, B_W'($urandom), 0, 0);
        end
        run_op(32'hFFFF_FFFF, 4'b1111, 0, 0);

        tag = "R2";
        wait_idle();
        repeat (4) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        while (cycles < 100000) @(negedge clk);
        errors++;
        $display("FAIL watchdog (%s) actual=%0d cycles expected=completion", tag, cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule